// File: doc/BRIEF.md
# Converter Host Bus Decoder and Result Formatter

This block sits between a host bus and the successive-approximation sequencer of a 12-bit converter. It decodes five host control lines: chip enable (active high), chip select (active low), read/convert select, a byte address bit and a bus-width strap. From them it produces a single-cycle convert-start strobe toward the sequencer, together with a latched short-cycle select. It also presents the sequencer's result on a 12-line data output. Each line group carries its own output enable, which stands in for the high-impedance state.

On a wide bus the result is read as one 12-bit word. On a narrow bus it is read as two left-justified bytes that share the upper eight data lines. The byte address bit picks the byte: one byte holds the eight most significant bits, and the other holds the four least significant bits followed by four zeros. When enable and width are strapped high and select and address are strapped low, the block runs stand-alone. A falling read/convert line then starts a conversion, and a high read/convert line with the converter idle drives the result.

The sequencer's busy flag and result word are inputs to this block. No analog or sequencing logic lives here.

Top module: `adcb_top`

## Requirements
- R1: While chip enable is low or chip select is high, start_o stays 0 and both output enables stay 0, whatever the other control lines do.
- R2: start_o pulses for exactly one cycle in either of two cases. The first is when the combined condition (enable high and select low) becomes true with read/convert low. The second is when read/convert falls while that condition holds. A condition held active produces no further pulse.
- R3: From the cycle after a start, short_o holds the byte address bit sampled with that start (0 selects a full 12-bit cycle, 1 selects an 8-bit cycle), until the next start.
- R4: A read happens when the combined condition holds with read/convert high and the converter idle. With the width strap high, a read drives data_o = result_i and sets both oe_hi_o and oe_lo_o.
- R5: With the width strap low and the address bit 0, a read drives data_o[11:4] = result_i[11:4] with oe_hi_o = 1, oe_lo_o = 0 and data_o[3:0] = 0.
- R6: With the width strap low and the address bit 1, a read drives data_o[11:8] = result_i[3:0] and data_o[7:4] = 0 (trailing zeros), with oe_hi_o = 1 and oe_lo_o = 0.
- R7: While busy_i is 1, start_o stays 0 and both output enables stay 0.
- R8: From a start until busy_i has been seen high once, both output enables stay 0 and further starts are refused.
- R9: Stand-alone mode has enable and width high and select and address low. In it, a falling read/convert starts a conversion and the outputs stay disabled. They become valid again only once read/convert is high and the cycle has completed (busy seen and then cleared).
- R10: Whenever an output enable is 0, the data lines of its group read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_i | input | 1 | Chip enable, active high |
| csel_ni | input | 1 | Chip select, active low |
| rdcv_i | input | 1 | 1 = read, 0 = convert |
| addr_i | input | 1 | Byte address / short-cycle select |
| wide_i | input | 1 | 1 = 12-bit word bus, 0 = 8-bit byte bus |
| busy_i | input | 1 | Sequencer busy flag |
| result_i | input | RES_W | Sequencer result |
| start_o | output | 1 | Convert-start strobe |
| short_o | output | 1 | Latched short-cycle select |
| data_o | output | RES_W | Data lines |
| oe_hi_o | output | 1 | Enable for the upper HI_W lines |
| oe_lo_o | output | 1 | Enable for the lower RES_W-HI_W lines |

## Verification
The bench builds the block at its default sizes: a 12-bit result split into an 8-line upper group and a 4-line lower group. At these sizes every combination of the five control lines can be swept, together with a spread of computed result words that includes all-zeros and all-ones. The expected data and enables are derived arithmetically from the width strap and address bit. Handshake sequences cover starts refused during pending and busy periods, and both stand-alone pulse polarities.

// File: rtl/adcb_pkg.sv
package adcb_pkg;
  typedef enum logic [1:0] {
    FMT_OFF  = 2'd0,
    FMT_WORD = 2'd1,
    FMT_HI   = 2'd2,
    FMT_LO   = 2'd3
  } fmt_e;
endpackage

// File: rtl/adcb_start.sv
module adcb_start (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic rdcv_i,
  input  logic addr_i,
  input  logic busy_i,
  output logic start_o,
  output logic short_o,
  output logic pend_o
);
  logic act_q, rc_q, pend_q, short_q;

  // start on rise of active with convert, or convert edge while active
  assign start_o = act_i & ~rdcv_i & ~busy_i & ~pend_q & (~act_q | rc_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      rc_q    <= 1'b0;
      pend_q  <= 1'b0;
      short_q <= 1'b0;
    end else begin
      act_q <= act_i;
      rc_q  <= rdcv_i;
      if (start_o) begin
        pend_q  <= 1'b1;
        short_q <= addr_i;
      end else if (busy_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign short_o = short_q;
  assign pend_o  = pend_q;

  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R2
  AST_SHORT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (short_o == $past(addr_i))); // R3
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !busy_i) |-> !start_o); // R8
endmodule

// File: rtl/adcb_fmt.sv
module adcb_fmt
  import adcb_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int HI_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  fmt_e             fmt_i,
  input  logic [RES_W-1:0] result_i,
  output logic [RES_W-1:0] data_o,
  output logic             oe_hi_o,
  output logic             oe_lo_o
);
  localparam int LO_W = RES_W - HI_W;

  if (LO_W < 1 || LO_W > HI_W) begin : g_bad
    initial $error("adcb_fmt: lower group must fit inside upper group");
  end

  always_comb begin
    data_o  = '0;
    oe_hi_o = 1'b0;
    oe_lo_o = 1'b0;
    unique case (fmt_i)
      FMT_WORD: begin
        data_o  = result_i;
        oe_hi_o = 1'b1;
        oe_lo_o = 1'b1;
      end
      FMT_HI: begin
        data_o[RES_W-1:LO_W] = result_i[RES_W-1:LO_W];
        oe_hi_o = 1'b1;
      end
      FMT_LO: begin
        data_o[RES_W-1 -: LO_W] = result_i[LO_W-1:0];
        oe_hi_o = 1'b1;
      end
      default: ;
    endcase
  end

  AST_LO_NEEDS_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_lo_o |-> oe_hi_o); // R4
  AST_LO_GROUP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_lo_o |-> (data_o[LO_W-1:0] == '0)); // R10
  AST_HI_GROUP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_hi_o |-> (data_o == '0)); // R10
endmodule

// File: rtl/adcb_top.sv
module adcb_top
  import adcb_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int HI_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cen_i,
  input  logic             csel_ni,
  input  logic             rdcv_i,
  input  logic             addr_i,
  input  logic             wide_i,
  input  logic             busy_i,
  input  logic [RES_W-1:0] result_i,
  output logic             start_o,
  output logic             short_o,
  output logic [RES_W-1:0] data_o,
  output logic             oe_hi_o,
  output logic             oe_lo_o
);
  logic act, pend, rd;
  fmt_e fmt;

  assign act = cen_i & ~csel_ni;

  adcb_start u_start (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .act_i   (act),
    .rdcv_i  (rdcv_i),
    .addr_i  (addr_i),
    .busy_i  (busy_i),
    .start_o (start_o),
    .short_o (short_o),
    .pend_o  (pend)
  );

  assign rd  = act & rdcv_i & ~busy_i & ~pend;
  assign fmt = !rd    ? FMT_OFF  :
               wide_i ? FMT_WORD :
               addr_i ? FMT_LO   : FMT_HI;

  adcb_fmt #(.RES_W(RES_W), .HI_W(HI_W)) u_fmt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fmt_i    (fmt),
    .result_i (result_i),
    .data_o   (data_o),
    .oe_hi_o  (oe_hi_o),
    .oe_lo_o  (oe_lo_o)
  );

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cen_i && !csel_ni) |-> !(start_o || oe_hi_o || oe_lo_o)); // R1
  AST_BUSY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !(start_o || oe_hi_o || oe_lo_o)); // R7
  AST_START_NOT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !oe_hi_o); // R8
endmodule

// File: tb/tb_adcb_top.sv
module tb_adcb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cen = 0, csel_n = 1, rdcv = 1, addr = 0, wide = 1, busy = 0;
  logic [11:0] res = '0;
  logic start, short_c, oe_hi, oe_lo;
  logic [11:0] data;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  adcb_top dut (
    .clk_i(clk), .rst_ni(rst_n), .cen_i(cen), .csel_ni(csel_n), .rdcv_i(rdcv),
    .addr_i(addr), .wide_i(wide), .busy_i(busy), .result_i(res),
    .start_o(start), .short_o(short_c), .data_o(data),
    .oe_hi_o(oe_hi), .oe_lo_o(oe_lo)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); #2; endtask

  function automatic logic [11:0] pat(input int i);
    return 12'((i * 1187 + 241) % 4096);
  endfunction

  task automatic chk_read(input string req, input logic w, input logic a);
    logic [11:0] e;
    e = w ? res : (a ? {res[3:0], 8'h00} : {res[11:4], 4'h0});
    chk(req, int'(data), int'(e));
    chk(req, int'({oe_hi, oe_lo}), w ? 3 : 2);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #2;
    chk("R1 reset", int'({start, oe_hi, oe_lo, data}), 0);
    rst_n = 1'b1;
    tick();
    // R1 sweep of inactive control combinations
    for (int m = 0; m < 32; m++) begin
      cen = m[0]; csel_n = m[1]; rdcv = m[2]; addr = m[3]; wide = m[4];
      res = pat(m);
      if (cen && !csel_n) continue;
      #2; chk("R1 inactive", int'({start, oe_hi, oe_lo, data}), 0);
      tick();
      chk("R1 inactive", int'({start, oe_hi, oe_lo, data}), 0);
    end
    // reads: activate with read high, no start (R2)
    cen = 1; csel_n = 1; rdcv = 1; tick();
    csel_n = 0; #2; chk("R2 read no start", int'(start), 0);
    for (int m = 0; m < 40; m++) begin
      wide = m[0]; addr = m[1];
      res = (m < 4) ? 12'h000 : (m < 8) ? 12'hFFF : pat(m);
      tick();
      chk(wide ? "R4 word" : (addr ? "R6 low byte" : "R5 high byte"), 0, 0);
      chk_read(wide ? "R4 word" : (addr ? "R6 low byte" : "R5 high byte"), wide, addr);
    end
    // start handshake, both short selections
    for (int a = 0; a < 2; a++) begin
      csel_n = 1; rdcv = 0; tick();
      chk("R1 no start deselected", int'(start), 0);
      addr = a[0]; csel_n = 0; #2;
      chk("R2 start on select", int'(start), 1);
      tick();
      chk("R2 single pulse", int'(start), 0);
      chk("R3 short latched", int'(short_c), a);
      addr = ~a[0]; tick(); tick();
      chk("R2 held no restart", int'(start), 0);
      chk("R3 short held", int'(short_c), a);
      rdcv = 1; wide = 1; tick();
      chk("R8 pending no read", int'({oe_hi, oe_lo}), 0);
      rdcv = 0; tick();
      chk("R8 pending no restart", int'(start), 0);
      busy = 1; tick();
      chk("R7 busy no start", int'(start), 0);
      rdcv = 1; tick();
      chk("R7 busy no read", int'({oe_hi, oe_lo, data}), 0);
      rdcv = 0; tick();
      chk("R7 busy no start on edge", int'(start), 0);
      busy = 0; rdcv = 1; res = pat(a + 50); tick();
      chk_read("R4 read after cycle", 1, addr);
      rdcv = 0; #2;
      chk("R2 start on read/convert fall", int'(start), 1);
      tick(); busy = 1; tick(); busy = 0; rdcv = 1; tick();
    end
    // stand-alone, low pulse
    cen = 1; csel_n = 0; wide = 1; addr = 0; rdcv = 1; res = 12'hA5C; tick();
    chk_read("R9 idle read", 1, 0);
    rdcv = 0; #2;
    chk("R9 fall starts", int'(start), 1);
    chk("R9 fall disables", int'({oe_hi, oe_lo}), 0);
    tick(); rdcv = 1; tick();
    chk("R9 disabled until done", int'({oe_hi, oe_lo, data}), 0);
    busy = 1; repeat (3) tick();
    chk("R9 disabled while busy", int'({oe_hi, oe_lo}), 0);
    busy = 0; res = 12'h3C7; tick();
    chk_read("R9 valid after done", 1, 0);
    // stand-alone, high pulse
    rdcv = 0; tick(); busy = 1; tick(); busy = 0; tick();
    chk("R9 low between pulses", int'({oe_hi, oe_lo}), 0);
    rdcv = 1; res = 12'h81E; tick();
    chk_read("R9 high pulse read", 1, 0);
    rdcv = 0; #2;
    chk("R9 high pulse fall starts", int'(start), 1);
    tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule